// File: doc/BRIEF.md
# Sign-Separated Prefix-Code Weight Decoder

This block turns a packed, entropy-coded stream of quantized convolution weights back into fixed-width sign-plus-magnitude codes. The stream arrives as 32-bit words on a valid/ready input. Within the stream every weight begins with a nonzero flag and its own sign bit. Only weights whose flag marks them as nonzero go on to carry a variable-length prefix code, and that code selects a shared magnitude symbol. A zero weight therefore costs exactly two bits, and the sign never enters the prefix code.

Before a block of weights is decoded, software-side logic loads a small code table through a write port. Each entry holds a code length, the code bits and the magnitude symbol. A start pulse then latches the number of weights to produce. The decoder emits exactly that many codes on a registered valid/ready output, which normally feeds one half of a ping-pong weight buffer. Any pad bits that follow the last weight in the final word are thrown away. If a prefix matches no table entry, the decoder raises a sticky error and halts.

Top module: `sgnhuf_wdec`

## Requirements
- R1: While reset is held, and in the first cycle after it, out_valid, busy, err and word_ready are all low.
- R2: Stream bits are consumed from bit 0 upward within each word, and words are consumed in the order they are accepted. Each weight is laid out as a nonzero flag bit (1 = nonzero), then a sign bit, then, only when the flag is 1, its prefix code.
- R3: A weight whose flag is 0 uses exactly two stream bits and is output as {sign, 0} (sign in the top bit of out_code).
- R4: A weight whose flag is 1 is output as {sign, symbol}, using the table entry whose first tbl_len code bits equal the next stream bits. Bit i of tbl_code is the i-th code bit on the wire.
- R5: A table write (tbl_we high) stores length, code and symbol at tbl_addr, and later weights use the new contents. A length of 0 disables the entry. Reset disables every entry.
- R6: Words are taken only while busy, while fewer than 9 bits are buffered and while the current weight cannot yet be decoded. A code split across two words decodes the same as one held within a single word.
- R7: A start latches weight_count and produces exactly that many outputs. After the last one is decoded, busy falls, the leftover bits in the buffer are dropped and no further word is read.
- R8: A start with weight_count equal to 0 leaves busy low and reads no word.
- R9: A start pulse while busy is ignored, including its weight_count.
- R10: While out_valid is high and out_ready is low, out_valid and out_code hold their values.
- R11: When a weight's flag is 1, 9 or more bits are buffered and no enabled entry matches, err rises and stays high, busy falls, and nothing more is output or read. The next accepted start clears err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a block of weights (only acted on while idle) |
| weight_count | input | CNT_W | Number of weights in the block |
| busy | output | 1 | Block in progress |
| err | output | 1 | Sticky unmatched-prefix error |
| word_valid | input | 1 | Stream word offered |
| word_data | input | WORD_W | Stream word, bit 0 first |
| word_ready | output | 1 | Stream word accepted this cycle if valid |
| tbl_we | input | 1 | Code-table write strobe |
| tbl_addr | input | MAG_W | Table entry index |
| tbl_len | input | LEN_W | Code length, 0 disables the entry |
| tbl_code | input | MAXL | Code bits, bit 0 sent first |
| tbl_sym | input | MAG_W | Magnitude symbol for the entry |
| out_valid | output | 1 | Decoded weight available |
| out_ready | input | 1 | Downstream takes the weight |
| out_code | output | MAG_W+1 | {sign, magnitude} |

## Verification
The embedded properties assume that start is a single-cycle pulse and that the table is not rewritten while a block is in progress. They also assume that a correctly formed stream uses a prefix-free table, so that a match on the bits already present is final. The stimulus writes table entries only between blocks. Apart from the two deliberate unmatched-prefix cases, it builds every stream from the same table image the decoder holds. It presents words strictly one block at a time, padded with zeros to a word boundary, so that a word left over from an earlier block can never be mistaken for pad bits.

// File: rtl/sgnhuf_pkg.sv
`timescale 1ns/1ps
package sgnhuf_pkg;
   // flag bit + sign bit carried ahead of every weight
   localparam int unsigned HDR_BITS = 2;

   // worst-case stream bits for one weight
   function automatic int unsigned worst_bits(input int unsigned maxl);
      return HDR_BITS + maxl;
   endfunction
endpackage

// File: rtl/sgnhuf_bitbuf.sv
`timescale 1ns/1ps
module sgnhuf_bitbuf #(
   parameter  int unsigned WORD_W = 32,
   parameter  int unsigned NEED   = 9,
   localparam int unsigned BUFW   = NEED - 1 + WORD_W,
   localparam int unsigned CW     = $clog2(BUFW + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              take,
   input  logic [CW-1:0]     take_n,
   input  logic              allow,
   input  logic              word_valid,
   input  logic [WORD_W-1:0] word_data,
   output logic              word_ready,
   output logic [BUFW-1:0]   bits,
   output logic [CW-1:0]     cnt
);
   localparam logic [CW-1:0] NEED_C = CW'(NEED);
   localparam logic [CW-1:0] WORD_C = CW'(WORD_W);
   localparam logic [CW-1:0] BUFW_C = CW'(BUFW);

   logic [BUFW-1:0] bits_q, nxt_bits, kept;
   logic [CW-1:0]   cnt_q, nxt_cnt, rem_cnt;
   logic            acc;

   always_comb begin
      word_ready = allow && (cnt_q < NEED_C);
      acc        = word_valid && word_ready;
      rem_cnt    = take ? (cnt_q - take_n) : cnt_q;
      kept       = take ? (bits_q >> take_n) : bits_q;
      nxt_bits   = kept;
      nxt_cnt    = rem_cnt;
      if (acc) begin
         nxt_bits = kept | (BUFW'(word_data) << rem_cnt);
         nxt_cnt  = rem_cnt + WORD_C;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         bits_q <= '0;
         cnt_q  <= '0;
      end else begin
         bits_q <= nxt_bits;
         cnt_q  <= nxt_cnt;
      end
   end

   assign bits = bits_q;
   assign cnt  = cnt_q;

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= BUFW_C);
   assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (take_n <= cnt_q));
endmodule

// File: rtl/sgnhuf_match.sv
`timescale 1ns/1ps
module sgnhuf_match #(
   parameter  int unsigned MAG_W = 3,
   parameter  int unsigned MAXL  = 7,
   parameter  int unsigned LEN_W = 3,
   localparam int unsigned NENT  = 1 << MAG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [MAG_W-1:0] wr_addr,
   input  logic [LEN_W-1:0] wr_len,
   input  logic [MAXL-1:0]  wr_code,
   input  logic [MAG_W-1:0] wr_sym,
   input  logic [MAXL-1:0]  look,
   input  logic [LEN_W-1:0] avail,
   output logic             hit,
   output logic [LEN_W-1:0] hit_len,
   output logic [MAG_W-1:0] hit_sym
);
   logic [LEN_W-1:0] len_q  [NENT];
   logic [MAXL-1:0]  code_q [NENT];
   logic [MAG_W-1:0] sym_q  [NENT];
   logic             ent_hit [NENT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < NENT; e++) begin
            len_q[e]  <= '0;
            code_q[e] <= '0;
            sym_q[e]  <= '0;
         end
      end else if (wr_en) begin
         len_q[wr_addr]  <= wr_len;
         code_q[wr_addr] <= wr_code;
         sym_q[wr_addr]  <= wr_sym;
      end
   end

   for (genvar e = 0; e < NENT; e++) begin : g_ent
      logic [MAXL-1:0] msk;
      assign msk = ~({MAXL{1'b1}} << len_q[e]);
      assign ent_hit[e] = (len_q[e] != '0) && (len_q[e] <= avail)
                          && (((look ^ code_q[e]) & msk) == '0);
   end

   always_comb begin
      hit     = 1'b0;
      hit_len = '0;
      hit_sym = '0;
      for (int e = NENT - 1; e >= 0; e--) begin
         if (ent_hit[e]) begin
            hit     = 1'b1;
            hit_len = len_q[e];
            hit_sym = sym_q[e];
         end
      end
   end

   assert_hit_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (hit_len != '0) && (hit_len <= avail));
endmodule

// File: rtl/sgnhuf_wdec.sv
`timescale 1ns/1ps
module sgnhuf_wdec #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned MAG_W  = 3,
   parameter int unsigned MAXL   = 7,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned LEN_W  = $clog2(MAXL + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  weight_count,
   output logic              busy,
   output logic              err,
   input  logic              word_valid,
   input  logic [WORD_W-1:0] word_data,
   output logic              word_ready,
   input  logic              tbl_we,
   input  logic [MAG_W-1:0]  tbl_addr,
   input  logic [LEN_W-1:0]  tbl_len,
   input  logic [MAXL-1:0]   tbl_code,
   input  logic [MAG_W-1:0]  tbl_sym,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [MAG_W:0]    out_code
);
   import sgnhuf_pkg::*;

   localparam int unsigned NEED = worst_bits(MAXL);
   localparam int unsigned BUFW = NEED - 1 + WORD_W;
   localparam int unsigned CW   = $clog2(BUFW + 1);
   localparam logic [CW-1:0] HDR_C  = CW'(HDR_BITS);
   localparam logic [CW-1:0] NEED_C = CW'(NEED);
   localparam logic [CW-1:0] MAXL_C = CW'(MAXL);

   if (MAXL < 1 || MAXL > 16) begin : g_bad_maxl
      $error("sgnhuf_wdec: MAXL out of range");
   end
   if (WORD_W < NEED) begin : g_bad_word
      $error("sgnhuf_wdec: WORD_W smaller than one worst-case weight");
   end
   if (LEN_W < $clog2(MAXL + 1)) begin : g_bad_len
      $error("sgnhuf_wdec: LEN_W cannot hold MAXL");
   end

   logic [BUFW-1:0]  bits;
   logic [CW-1:0]    cnt;
   logic             active_q, err_q, ov_q;
   logic [CNT_W-1:0] left_q;
   logic [MAG_W:0]   od_q;
   logic             start_ok, nzf, sgn, have, bad, fire, last, flush, allow;
   logic [MAXL-1:0]  look;
   logic [LEN_W-1:0] avail, hit_len;
   logic [MAG_W-1:0] hit_sym;
   logic             hit;
   logic [CW-1:0]    used;

   always_comb begin
      start_ok = start && !active_q;
      nzf      = bits[0];
      sgn      = bits[1];
      look     = bits[HDR_BITS +: MAXL];
      if (cnt <= HDR_C)                 avail = '0;
      else if (cnt - HDR_C >= MAXL_C)   avail = LEN_W'(MAXL);
      else                              avail = LEN_W'(cnt - HDR_C);
      have  = active_q && (cnt >= HDR_C) && (!nzf || hit);
      bad   = active_q && nzf && !hit && (cnt >= NEED_C);
      fire  = have && (!ov_q || out_ready);
      last  = fire && (left_q == CNT_W'(1));
      used  = nzf ? (HDR_C + CW'(hit_len)) : HDR_C;
      flush = start_ok || last || bad;
      allow = active_q && !have;
   end

   sgnhuf_bitbuf #(.WORD_W(WORD_W), .NEED(NEED)) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .take       (fire),
      .take_n     (used),
      .allow      (allow),
      .word_valid (word_valid),
      .word_data  (word_data),
      .word_ready (word_ready),
      .bits       (bits),
      .cnt        (cnt)
   );

   sgnhuf_match #(.MAG_W(MAG_W), .MAXL(MAXL), .LEN_W(LEN_W)) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tbl_we),
      .wr_addr (tbl_addr),
      .wr_len  (tbl_len),
      .wr_code (tbl_code),
      .wr_sym  (tbl_sym),
      .look    (look),
      .avail   (avail),
      .hit     (hit),
      .hit_len (hit_len),
      .hit_sym (hit_sym)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         err_q    <= 1'b0;
         left_q   <= '0;
      end else if (start_ok) begin
         active_q <= (weight_count != '0);
         left_q   <= weight_count;
         err_q    <= 1'b0;
      end else begin
         if (bad) begin
            err_q    <= 1'b1;
            active_q <= 1'b0;
         end
         if (fire) begin
            left_q <= left_q - CNT_W'(1);
            if (last) active_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ov_q <= 1'b0;
         od_q <= '0;
      end else if (fire) begin
         ov_q <= 1'b1;
         od_q <= {sgn, (nzf ? hit_sym : {MAG_W{1'b0}})};
      end else if (out_ready) begin
         ov_q <= 1'b0;
      end
   end

   assign busy      = active_q;
   assign err       = err_q;
   assign out_valid = ov_q;
   assign out_code  = od_q;

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ov_q && !out_ready) |=> (ov_q && $stable(od_q)));
   assert_idle_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q |-> !word_ready);
   assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !start) |=> err_q);
   assert_err_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> !(word_valid && word_ready));
   assert_fit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> (used <= cnt));
endmodule

// File: tb/sgnhuf_wdec_tb.sv
`timescale 1ns/1ps
module sgnhuf_wdec_tb;
   localparam int WORD_W = 32;
   localparam int MAG_W  = 3;
   localparam int MAXL   = 7;
   localparam int CNT_W  = 16;
   localparam int LEN_W  = 3;

   logic              clk, rst_n, start, busy, err;
   logic [CNT_W-1:0]  weight_count;
   logic              word_valid, word_ready;
   logic [WORD_W-1:0] word_data;
   logic              tbl_we;
   logic [MAG_W-1:0]  tbl_addr, tbl_sym;
   logic [LEN_W-1:0]  tbl_len;
   logic [MAXL-1:0]   tbl_code;
   logic              out_valid, out_ready;
   logic [MAG_W:0]    out_code;

   sgnhuf_wdec #(.WORD_W(WORD_W), .MAG_W(MAG_W), .MAXL(MAXL), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .weight_count(weight_count),
      .busy(busy), .err(err), .word_valid(word_valid), .word_data(word_data),
      .word_ready(word_ready), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
      .tbl_len(tbl_len), .tbl_code(tbl_code), .tbl_sym(tbl_sym),
      .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   int tl [8];
   int tc [8];
   bit bq [$];
   logic [WORD_W-1:0] wq [$];
   logic [MAG_W:0] eq [$];
   int nchk = 0, nfail = 0, rx = 0;
   int wstall = 0, ostall = 0;
   bit hold_pend = 0;
   logic [MAG_W:0] hold_code;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
      word_valid = (wq.size() != 0) && (($urandom % 100) >= wstall);
      word_data  = (wq.size() != 0) ? wq[0] : '0;
      out_ready  = ($urandom % 100) >= ostall;
      #1;
      if (hold_pend)
         chk(out_valid && (out_code == hold_code), "R10 hold", int'(out_code), int'(hold_code));
      hold_pend = out_valid && !out_ready;
      hold_code = out_code;
      if (word_valid && word_ready) void'(wq.pop_front());
      if (out_valid && out_ready) begin
         rx++;
         if (eq.size() == 0) chk(1'b0, "R7 extra output", int'(out_code), -1);
         else begin
            logic [MAG_W:0] e;
            e = eq.pop_front();
            chk(out_code == e, (e[MAG_W-1:0] == 0) ? "R3 zero weight" : "R4 coded weight",
                int'(out_code), int'(e));
         end
      end
   endtask

   task automatic put_w(input bit s, input int mag);
      if (mag == 0) begin
         bq.push_back(1'b0); bq.push_back(s);
         eq.push_back({s, 3'b000});
      end else begin
         bq.push_back(1'b1); bq.push_back(s);
         for (int i = 0; i < tl[mag]; i++) bq.push_back(bit'((tc[mag] >> i) & 1));
         eq.push_back({s, 3'(mag)});
      end
   endtask

   task automatic put_rand(input int n);
      for (int i = 0; i < n; i++)
         put_w(bit'($urandom % 2), (($urandom % 3) == 0) ? 0 : int'($urandom % 8));
   endtask

   task automatic seal(output int nw);
      nw = 0;
      while (bq.size() > 0) begin
         logic [WORD_W-1:0] w;
         w = '0;
         for (int i = 0; i < WORD_W; i++) if (bq.size() > 0) w[i] = bq.pop_front();
         wq.push_back(w);
         nw++;
      end
   endtask

   task automatic wr_ent(input int e);
      tbl_we = 1'b1; tbl_addr = 3'(e); tbl_len = 3'(tl[e]);
      tbl_code = 7'(tc[e]); tbl_sym = 3'(e);
      cyc();
      tbl_we = 1'b0;
   endtask

   task automatic load_a();
      tl[0] = 0; tc[0] = 0;
      for (int k = 1; k <= 6; k++) begin tl[k] = k; tc[k] = (1 << (k - 1)) - 1; end
      tl[7] = 7; tc[7] = 63;
      for (int e = 0; e < 8; e++) wr_ent(e);
   endtask

   task automatic run_block(input int wc, input int expn, input bit poke);
      int guard;
      rx = 0; guard = 0;
      weight_count = 16'(wc); start = 1'b1;
      cyc();
      start = 1'b0;
      while ((busy || rx < expn) && guard < 20000) begin
         cyc(); guard++;
         if (poke && guard == 3) begin
            weight_count = 16'd99; start = 1'b1;   // R9: ignored while busy
            cyc();
            start = 1'b0; weight_count = 16'(wc);
         end
      end
      chk(rx == expn, "R7 output count", rx, expn);
      chk(!busy, "R7 busy low at end", int'(busy), 0);
   endtask

   initial begin
      #(20 * 150000);
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end

   initial begin
      int nw, nx, ny;
      rst_n = 1'b0; start = 1'b0; weight_count = '0; word_valid = 1'b0;
      word_data = '0; tbl_we = 1'b0; tbl_addr = '0; tbl_len = '0;
      tbl_code = '0; tbl_sym = '0; out_ready = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk(!out_valid && !busy && !err && !word_ready, "R1 reset",
          int'({out_valid, busy, err, word_ready}), 0);
      rst_n = 1'b1;
      cyc();
      chk(!out_valid && !busy && !err && !word_ready, "R1 after reset",
          int'({out_valid, busy, err, word_ready}), 0);

      load_a();

      // R2/R3/R4: mixed block with stalls on both sides
      wstall = 25; ostall = 25;
      put_rand(40); seal(nw);
      run_block(40, 40, 0);
      chk(wq.size() == 0, "R2 all words consumed", wq.size(), 0);
      chk(!err, "R4 no error", int'(err), 0);

      // R3: zero weights only, 16 per word
      for (int i = 0; i < 32; i++) put_w(bit'($urandom % 2), 0);
      seal(nw);
      run_block(32, 32, 0);
      chk(wq.size() == 0, "R3 two words exactly", wq.size(), 0);

      // R6: longest codes straddle word boundaries
      for (int i = 0; i < 12; i++) put_w(bit'(i % 2), (i % 3 == 0) ? 6 : 7);
      seal(nw);
      run_block(12, 12, 0);

      // R7: back-to-back blocks, pad bits dropped, next block untouched
      put_rand(10); seal(nx);
      put_rand(10); seal(ny);
      run_block(10, 10, 0);
      chk(wq.size() == ny, "R7 next block words untouched", wq.size(), ny);
      run_block(10, 10, 0);
      chk(wq.size() == 0, "R7 second block consumed", wq.size(), 0);

      // R10: heavy output backpressure
      ostall = 70;
      put_rand(20); seal(nw);
      run_block(20, 20, 0);
      ostall = 25;

      // R8: zero count
      wq.push_back(32'hFFFF_FFFF);
      weight_count = '0; start = 1'b1; cyc(); start = 1'b0;
      repeat (5) cyc();
      chk(!busy, "R8 busy stays low", int'(busy), 0);
      chk(wq.size() == 1, "R8 no word read", wq.size(), 1);
      wq.delete();

      // R9: start while busy ignored
      put_rand(30); seal(nw);
      run_block(30, 30, 1);
      repeat (8) cyc();
      chk(rx == 30 && !busy, "R9 no extra weights", rx, 30);

      // R11: unmatched prefix
      put_w(1'b0, 2); put_w(1'b1, 0);
      bq.push_back(1'b1); bq.push_back(1'b0);
      for (int i = 0; i < 7; i++) bq.push_back(1'b1);
      seal(nw);
      run_block(5, 2, 0);
      repeat (10) cyc();
      chk(err, "R11 err set", int'(err), 1);
      chk(rx == 2, "R11 no output after error", rx, 2);
      chk(!busy, "R11 busy low", int'(busy), 0);
      wq.delete();
      put_rand(8); seal(nw);
      run_block(8, 8, 0);
      chk(!err, "R11 err cleared by start", int'(err), 0);

      // R5: reload with swapped codes
      tl[1] = 7; tc[1] = 63; tl[7] = 1; tc[7] = 0;
      wr_ent(1); wr_ent(7);
      put_rand(20); seal(nw);
      run_block(20, 20, 0);
      chk(!err, "R5 reloaded table decodes", int'(err), 0);

      // R5: disabled entry no longer matches
      load_a();
      tl[3] = 0; wr_ent(3);
      put_w(1'b1, 5);
      bq.push_back(1'b1); bq.push_back(1'b0);
      bq.push_back(1'b1); bq.push_back(1'b1); bq.push_back(1'b0);
      seal(nw);
      run_block(3, 1, 0);
      chk(err, "R5 disabled entry gives error", int'(err), 1);
      wq.delete();

      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end
endmodule